// File: doc/BRIEF.md
# Time-Interleaved Bitstream FIR Decimator

This block turns a two-level oversampled bitstream into signed multibit samples at a lower rate. It uses one long FIR filter whose length is a whole multiple of the decimation ratio. It never forms the filter output at the input rate. Output windows of length TAPS start every DECIM input samples, so TAPS/DECIM windows overlap at any time. Each window has its own accumulator. All accumulators share one coefficient table and a single adder, and the block visits them in turn.

Each accepted input bit starts a short burst of TAPS/DECIM processing cycles. In slot j of that burst, accumulator j reads the coefficient at its own tap position. It adds that coefficient when the bit is 1 and subtracts it when the bit is 0. When an accumulator reaches the last tap of its window, it hands its total to the output and begins its next window at tap zero. Because the input is two-level, no multiplier is needed. The rate of work per accumulator falls by the number of accumulators.

Top module: `bitstream_fir_decim`

## Requirements
- R1: While rstN is low, and after it is released, outValid is 0 and outData is 0. The block then counts input samples from zero again.
- R2: An accepted bit of 1 counts as +1 and a bit of 0 counts as -1.
- R3: Input samples are numbered i from 0 since reset. For an output emitted on sample i, outData equals the sum over t = 0..TAPS-1 of h(t)·s(i-TAPS+1+t), where s is the ±1 value of the sample.
- R4: The coefficients are h(t) = ((m·211 + 97) mod 8192) - 4000, where m = min(t, TAPS-1-t). The table is therefore symmetric.
- R5: The first output is produced on sample TAPS-1. After that, exactly one output is produced on every sample whose index i satisfies (i+1) mod DECIM = 0. No other sample produces an output.
- R6: The output for sample i comes from accumulator j = ((i+1)/DECIM) mod (TAPS/DECIM). Take the clock edge that accepts sample i as edge A. outValid is then a one-cycle pulse registered at edge A+1+j, which falls inside the sample's processing burst.
- R7: inValid is sampled only when the block is idle. A pulse at any of the TAPS/DECIM edges after an acceptance is ignored, and it changes no output. Inputs must therefore be at least TAPS/DECIM+1 cycles apart.
- R8: outData is 16 + log2(TAPS) + 1 bits wide. An all-ones or all-zeros stream gives the exact positive or negative sum of the whole table, with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input sample strobe, accepted when idle |
| inBit | input | 1 | Bitstream sample, 1 = +1, 0 = -1 |
| outValid | output | 1 | One-cycle strobe for a new output sample |
| outData | output | ACC_W | Signed filter output |

## Verification
When the clock edge that accepts input sample i is A, the output for that sample is registered at edge A+1+j. Here j = ((i+1)/DECIM) mod (TAPS/DECIM), so the output lands 1 to TAPS/DECIM edges after acceptance. The driver reads the cycle count on the falling edge before it raises inValid. From that count it computes the exact due cycle and pushes it into the queue with the expected sum. The monitor samples on falling edges and checks both the value and the cycle of each strobe, so an output that is early, late or missing is reported. Ignored strobes are injected inside the busy window with the bit inverted, and the scoreboard must still match.

// File: rtl/bitstream_fir_decim_pkg.sv
package bitstream_fir_decim_pkg;

  // strobes handed from the sequencer to the datapath
  typedef struct packed {
    logic step;   // update the addressed accumulator
    logic first;  // tap zero: load instead of add
    logic emit;   // last tap: publish the result
    logic sign;   // latched input bit, 1 = +1
  } ctl_t;

  // symmetric coefficient generator
  function automatic int tapWeight(input int t, input int taps);
    int m;
    m = (t < taps - 1 - t) ? t : taps - 1 - t;
    return ((m * 211 + 97) % 8192) - 4000;
  endfunction

endpackage

// File: rtl/bitstream_fir_decim_rom.sv
module bitstream_fir_decim_rom #(
  parameter int TAPS   = 128,
  parameter int COEF_W = 16,
  localparam int ADDR_W = $clog2(TAPS)
) (
  input  logic        [ADDR_W-1:0] tap,
  output logic signed [COEF_W-1:0] coef
);
  import bitstream_fir_decim_pkg::*;

  logic signed [COEF_W-1:0] table_q [TAPS];

  for (genvar g = 0; g < TAPS; g++) begin : gTab
    assign table_q[g] = COEF_W'(tapWeight(g, TAPS));
  end

  assign coef = table_q[tap];
endmodule

// File: rtl/bitstream_fir_decim_ctrl.sv
module bitstream_fir_decim_ctrl
  import bitstream_fir_decim_pkg::*;
#(
  parameter int TAPS  = 128,
  parameter int DECIM = 16,
  localparam int NUM_ACC = TAPS / DECIM,
  localparam int ADDR_W  = $clog2(TAPS),
  localparam int SLOT_W  = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1,
  localparam int FILL_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inBit,
  output ctl_t              ctl,
  output logic [SLOT_W-1:0] slot,
  output logic [ADDR_W-1:0] tap,
  output logic              busy
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_ACC - 1);
  localparam logic [FILL_W-1:0] FILL_MAX  = FILL_W'(TAPS);
  localparam logic [ADDR_W-1:0] LAST_TAP  = ADDR_W'(TAPS - 1);

  logic [ADDR_W-1:0] pos;     // sample index modulo TAPS
  logic [FILL_W-1:0] fill;    // samples seen, saturating at TAPS
  logic              bitReg;
  logic [FILL_W-1:0] offset;
  logic              active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      slot   <= '0;
      pos    <= '0;
      fill   <= '0;
      bitReg <= 1'b0;
    end else if (!busy) begin
      if (inValid) begin
        busy   <= 1'b1;
        slot   <= '0;
        bitReg <= inBit;
      end
    end else begin
      if (slot == LAST_SLOT) begin
        busy <= 1'b0;
        slot <= '0;
        pos  <= pos + 1'b1;
        if (fill < FILL_MAX) fill <= fill + 1'b1;
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end

  // accumulator j runs tap (pos - j*DECIM) once j*DECIM samples have arrived
  assign offset = FILL_W'(slot) * FILL_W'(DECIM);
  assign tap    = pos - offset[ADDR_W-1:0];
  assign active = fill >= offset;

  always_comb begin
    ctl.step  = busy && active;
    ctl.first = tap == '0;
    ctl.emit  = busy && active && (tap == LAST_TAP);
    ctl.sign  = bitReg;
  end
endmodule

// File: rtl/bitstream_fir_decim_dp.sv
module bitstream_fir_decim_dp
  import bitstream_fir_decim_pkg::*;
#(
  parameter int NUM_ACC = 8,
  parameter int COEF_W  = 16,
  parameter int ACC_W   = 24,
  localparam int SLOT_W = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctl_t                     ctl,
  input  logic        [SLOT_W-1:0] slot,
  input  logic signed [COEF_W-1:0] coef,
  output logic                     outValid,
  output logic signed [ACC_W-1:0]  outData
);
  logic signed [ACC_W-1:0] accView [NUM_ACC];
  logic signed [ACC_W-1:0] coefExt;
  logic signed [ACC_W-1:0] term;
  logic signed [ACC_W-1:0] base;
  logic signed [ACC_W-1:0] sum;

  assign coefExt = {{(ACC_W - COEF_W){coef[COEF_W-1]}}, coef};
  assign term    = ctl.sign ? coefExt : -coefExt;
  assign base    = ctl.first ? '0 : accView[slot];
  assign sum     = base + term;

  for (genvar g = 0; g < NUM_ACC; g++) begin : gAcc
    logic signed [ACC_W-1:0] accQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                  accQ <= '0;
      else if (ctl.step && slot == SLOT_W'(g))    accQ <= sum;
    end
    assign accView[g] = accQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= ctl.emit;
      if (ctl.emit) outData <= sum;
    end
  end
endmodule

// File: rtl/bitstream_fir_decim.sv
module bitstream_fir_decim
  import bitstream_fir_decim_pkg::*;
#(
  parameter int TAPS   = 128,
  parameter int DECIM  = 16,
  parameter int COEF_W = 16,
  localparam int NUM_ACC = TAPS / DECIM,
  localparam int ADDR_W  = $clog2(TAPS),
  localparam int SLOT_W  = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1,
  localparam int ACC_W   = COEF_W + ADDR_W + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic                    inBit,
  output logic                    outValid,
  output logic signed [ACC_W-1:0] outData
);
  ctl_t                     ctl;
  logic        [SLOT_W-1:0] slot;
  logic        [ADDR_W-1:0] tap;
  logic                     busy;
  logic signed [COEF_W-1:0] coef;

  bitstream_fir_decim_ctrl #(.TAPS(TAPS), .DECIM(DECIM)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inBit(inBit),
    .ctl(ctl), .slot(slot), .tap(tap), .busy(busy)
  );

  bitstream_fir_decim_rom #(.TAPS(TAPS), .COEF_W(COEF_W)) u_rom (
    .tap(tap), .coef(coef)
  );

  bitstream_fir_decim_dp #(.NUM_ACC(NUM_ACC), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .slot(slot), .coef(coef),
    .outValid(outValid), .outData(outData)
  );
endmodule

// File: rtl/bitstream_fir_decim_chk.sv
module bitstream_fir_decim_chk #(
  parameter int TAPS  = 128,
  parameter int DECIM = 16,
  localparam int CNT_W = $clog2(TAPS) + 1,
  localparam int PH_W  = (DECIM > 1) ? $clog2(DECIM) : 1
) (
  input logic clk,
  input logic rstN,
  input logic inValid,
  input logic busy,
  input logic sampleBit,
  input logic outValid
);
  logic [CNT_W-1:0] acceptCnt;
  logic [PH_W-1:0]  phaseCnt;
  logic             accept;

  assign accept = inValid && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acceptCnt <= '0;
      phaseCnt  <= '0;
    end else if (accept) begin
      if (acceptCnt < CNT_W'(TAPS)) acceptCnt <= acceptCnt + 1'b1;
      phaseCnt <= (phaseCnt == PH_W'(DECIM - 1)) ? '0 : phaseCnt + 1'b1;
    end
  end

  // R5
  first_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> acceptCnt == CNT_W'(TAPS));

  // R5
  cadence_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> phaseCnt == '0);

  // R6
  pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R6
  in_burst_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(busy));

  // R7
  hold_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(sampleBit));
endmodule

bind bitstream_fir_decim bitstream_fir_decim_chk #(.TAPS(TAPS), .DECIM(DECIM)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .busy(busy),
  .sampleBit(ctl.sign), .outValid(outValid)
);

// File: tb/bitstream_fir_decim_bench.sv
module bitstream_fir_decim_bench;
  localparam int TAPS = 128;
  localparam int DECIM = 16;
  localparam int NACC = TAPS / DECIM;
  localparam int ACC_W = 16 + 7 + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inBit = 1'b0;
  logic outValid;
  logic signed [ACC_W-1:0] outData;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int sampleIdx = 0;
  bit hist [0:2047];
  int expVal [$];
  int expDue [$];
  int expReq [$];
  bit finished = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bitstream_fir_decim u_bitstream_fir_decim (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inBit(inBit),
    .outValid(outValid), .outData(outData)
  );

  function automatic int hRef(int t);
    int m;
    m = (t < TAPS - 1 - t) ? t : TAPS - 1 - t;
    return ((m * 211 + 97) % 8192) - 4000;
  endfunction

  // monitor: pops the scoreboard on each output strobe
  always @(negedge clk) begin
    if (rstN && outValid) begin
      checks++;
      if (expVal.size() == 0) begin
        fails++;
        $display("FAIL R5 unexpected output %0d at cycle %0d, expected none", outData, cyc);
      end else begin
        int v, d, r;
        v = expVal.pop_front();
        d = expDue.pop_front();
        r = expReq.pop_front();
        if (int'(outData) != v) begin
          fails++;
          $display("FAIL R%0d value actual %0d expected %0d", r, outData, v);
        end
        checks++;
        if (cyc != d) begin
          fails++;
          $display("FAIL R6 cycle actual %0d expected %0d", cyc, d);
        end
      end
    end
  end

  task automatic sendBit(input bit b, input bit poke, input int req);
    int c, sum, j;
    @(negedge clk);
    c = cyc;
    inValid = 1'b1;
    inBit = b;
    hist[sampleIdx] = b;
    if (sampleIdx >= TAPS - 1 && ((sampleIdx + 1) % DECIM) == 0) begin
      sum = 0;
      for (int t = 0; t < TAPS; t++)
        sum += hist[sampleIdx - TAPS + 1 + t] ? hRef(t) : -hRef(t);
      j = ((sampleIdx + 1) / DECIM) % NACC;
      expVal.push_back(sum);
      expDue.push_back(c + j + 2);
      expReq.push_back(req);
    end
    sampleIdx++;
    @(negedge clk);
    if (poke) begin
      // R7: inverted strobe inside the busy window must be ignored
      inBit = ~b;
      repeat (3) @(negedge clk);
    end
    inValid = 1'b0;
    repeat (9) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    inValid = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || outData !== '0) begin
      fails++;
      $display("FAIL R1 reset outputs actual %b/%0d expected 0/0", outValid, outData);
    end
    rstN = 1'b1;
    sampleIdx = 0;
    repeat (2) @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || outData !== '0) begin
      fails++;
      $display("FAIL R1 after release actual %b/%0d expected 0/0", outValid, outData);
    end
  endtask

  task automatic drainCheck();
    repeat (12) @(negedge clk);
    checks++;
    if (expVal.size() != 0) begin
      fails++;
      $display("FAIL R5 missing outputs actual 0 expected %0d", expVal.size());
    end
    expVal.delete();
    expDue.delete();
    expReq.delete();
  endtask

  initial begin
    logic [15:0] lfsr;
    doReset();
    // R8: all ones, positive full-table sum (also R2, R5)
    for (int i = 0; i < 160; i++) sendBit(1'b1, 1'b0, 8);
    drainCheck();
    // R1: restart mid-stream, then all zeros (R8 negative, R2)
    for (int i = 0; i < 40; i++) sendBit(1'b1, 1'b0, 8);
    expVal.delete(); expDue.delete(); expReq.delete();
    doReset();
    for (int i = 0; i < 160; i++) sendBit(1'b0, 1'b0, 8);
    drainCheck();
    doReset();
    // R3, R7: alternating pattern with ignored strobes
    for (int i = 0; i < 200; i++) sendBit(i[0], (i % 7) == 3, 7);
    drainCheck();
    doReset();
    // R3, R4: pseudo-random stream checks every tap weight
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      sendBit(lfsr[0], 1'b0, 3);
      lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    end
    drainCheck();
    // R6: period-3 pattern, output slots rotate through all accumulators
    for (int i = 0; i < 300; i++) sendBit((i % 3) != 2, 1'b0, 6);
    drainCheck();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule